// File: doc/BRIEF.md
# Descriptor Chain Walker with CRC Integrity Check

The block follows a linked chain of transfer descriptors held in system memory and hands each one, after an optional integrity check, to a downstream channel. Each descriptor occupies six consecutive 32-bit words: source address, destination address, control A, control B, a pointer to the next descriptor, and a word whose low 16 bits hold a CRC16 of the first five. The block reads these words one at a time through a simple request/response memory port. It computes the CRC itself and compares the result with the stored value.

A start pulse with a non-zero first-descriptor address launches the walk. A descriptor that passes the check is presented on a valid/ready port. Once it is accepted, the block follows its next pointer. A zero next pointer ends the chain with a one-cycle done pulse. A failed check raises a sticky integrity error and halts the walk. While the error is set, start pulses are refused. A clear pulse removes the error. When the check is disabled, the CRC word is never read.

Top module: `dscr_chain_walker`

## Requirements
- R1: During and after reset, no memory request, descriptor valid, integrity error, done or busy is asserted.
- R2: A start pulse begins a walk only when the first-descriptor address is non-zero and no integrity error is set. Otherwise it has no effect: no request is issued and busy stays low.
- R3: Descriptor words are read at byte offsets +0x0, +0x4, +0x8, +0xC, +0x10 and then +0x14, in that order. A request is a single-cycle pulse. At most one read is outstanding, and the next request follows only after the response.
- R4: The CRC is CRC16 with polynomial 0x1021 and initial value 0xFFFF. It is processed MSB first over the five words in address order, bit 31 of each word first. It is compared with bits [15:0] of the +0x14 word; bits [31:16] of that word are ignored.
- R5: Before hashing, bits [15:0] (transfer size) and bit 31 (done flag) of control A are treated as zero, so their stored values do not affect the check. The presented control A keeps its stored value.
- R6: A descriptor that passes the check is presented with valid high. Its five fields stay stable until ready is seen.
- R7: On a CRC mismatch, the integrity error is set in the cycle after the CRC response. The failing descriptor is not presented. The error stays set until cleared, and no memory request is issued while it is set.
- R8: A clear pulse removes a set integrity error in the following cycle.
- R9: With the check disabled at start, only the five words at +0x0 to +0x10 are read, and no integrity error can arise.
- R10: After acceptance, a non-zero next pointer becomes the base of the next descriptor. A zero next pointer produces a done pulse of one cycle in the cycle after acceptance, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse for a walk |
| first_addr_i | input | 32 | Byte address of the first descriptor |
| check_en_i | input | 1 | Integrity check enable, sampled at start |
| err_clr_i | input | 1 | Clear pulse for the integrity error |
| mem_req_valid_o | output | 1 | Word read request, one cycle |
| mem_req_addr_o | output | 32 | Byte address of the requested word |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 32 | Read response data |
| dsc_valid_o | output | 1 | Descriptor valid toward the channel |
| dsc_ready_i | input | 1 | Channel accepts the descriptor |
| dsc_src_o | output | 32 | Source address field |
| dsc_dst_o | output | 32 | Destination address field |
| dsc_ctla_o | output | 32 | Control A field, as stored |
| dsc_ctlb_o | output | 32 | Control B field |
| dsc_next_o | output | 32 | Next-descriptor pointer |
| integ_err_o | output | 1 | Sticky integrity error |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse at the end of the chain |

## Verification
The assertions assume that the memory returns exactly one response per request, and never in the cycle the request is issued. They also assume that a clear pulse is applied only when no CRC response is being consumed. The bench responder answers each request after one to three cycles and only in the cycles that follow it. Start and clear pulses are driven only while the block is idle, and ready is randomised, so the hold-until-accepted rule sees both stalls and immediate acceptance.

// File: rtl/dcw_pkg.sv
// Shared definitions for the descriptor chain walker.
// Assumes a descriptor of five payload words plus one CRC word.
package dcw_pkg;
    localparam int unsigned DCW_WORDS    = 5;
    localparam int unsigned DCW_CTLA_IDX = 2;
    localparam int unsigned DCW_NEXT_IDX = 4;

    typedef enum logic [1:0] {
        WALK_IDLE,
        WALK_REQ,
        WALK_WAIT,
        WALK_PRESENT
    } walk_state_t;
endpackage

// File: rtl/dcw_crc_acc.sv
// CRC accumulator: folds one DATA_W word per update into a CRC_W register,
// MSB of the word first, generator POLY. init_i reloads INIT.
// Assumes init_i and upd_i are never high together.
module dcw_crc_acc #(
    parameter int unsigned      DATA_W = 32,
    parameter int unsigned      CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY   = 16'h1021,
    parameter logic [CRC_W-1:0] INIT   = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              upd_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [CRC_W-1:0]  crc_o
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nxt;

    // Serial polynomial division of one word, unrolled over its bits.
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = crc_q;
        for (int b = DATA_W - 1; b >= 0; b--) begin
            fb  = acc[CRC_W-1] ^ word_i[b];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) acc = acc ^ POLY;
        end
        crc_nxt = acc;
    end

    // CRC register: reload on init, fold on update.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= INIT;
        else if (init_i) crc_q <= INIT;
        else if (upd_i)  crc_q <= crc_nxt;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/dcw_word_bank.sv
// Holds the payload words of the descriptor being fetched.
// One word is written per cycle at wr_idx_i. Indices at or above WORDS are dropped.
module dcw_word_bank #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WORDS  = 5,
    parameter int unsigned IDX_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [IDX_W-1:0]             wr_idx_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    output logic [WORDS-1:0][DATA_W-1:0] words_o
);
    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        // Storage for payload word g.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    words_o[g] <= '0;
            else if (wr_en_i && wr_idx_i == IDX_W'(g))     words_o[g] <= wr_data_i;
        end
    end
endmodule

// File: rtl/dscr_chain_walker.sv
// Walks a linked chain of descriptors. Each descriptor is read word by word
// over a one-outstanding memory port, optionally checked with a CRC, and
// presented on a valid/ready port. A mismatch sets a sticky error and halts.
// Assumes: one response per request, never in the request cycle;
// ADDR_W equals DATA_W; err_clr_i is not pulsed while a CRC word is consumed.
module dscr_chain_walker
    import dcw_pkg::*;
#(
    parameter int unsigned      ADDR_W   = 32,
    parameter int unsigned      DATA_W   = 32,
    parameter int unsigned      CRC_W    = 16,
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
    parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF,
    parameter int unsigned      SIZE_W   = 16,
    parameter int unsigned      DONE_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] first_addr_i,
    input  logic              check_en_i,
    input  logic              err_clr_i,
    output logic              mem_req_valid_o,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [DATA_W-1:0] mem_rsp_data_i,
    output logic              dsc_valid_o,
    input  logic              dsc_ready_i,
    output logic [DATA_W-1:0] dsc_src_o,
    output logic [DATA_W-1:0] dsc_dst_o,
    output logic [DATA_W-1:0] dsc_ctla_o,
    output logic [DATA_W-1:0] dsc_ctlb_o,
    output logic [DATA_W-1:0] dsc_next_o,
    output logic              integ_err_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int unsigned WORDS      = DCW_WORDS;
    localparam int unsigned IDX_W      = $clog2(WORDS + 1);
    localparam int unsigned BYTE_SHIFT = $clog2(DATA_W / 8);
    localparam logic [DATA_W-1:0] CTLA_MASK =
        (DATA_W'(1) << DONE_BIT) | ((DATA_W'(1) << SIZE_W) - DATA_W'(1));

    walk_state_t              state_q;
    logic [ADDR_W-1:0]        base_q;
    logic [IDX_W-1:0]         idx_q;
    logic                     chk_q;
    logic                     err_q;
    logic                     done_q;
    logic [WORDS-1:0][DATA_W-1:0] words;
    logic [CRC_W-1:0]         crc_val;

    logic              rsp_take;
    logic              payload_take;
    logic              crc_take;
    logic              crc_ok;
    logic              launch;
    logic              accept;
    logic [ADDR_W-1:0] next_ptr;
    logic [DATA_W-1:0] hash_word;

    // Decode of the handshake events of the current cycle.
    always_comb begin
        rsp_take     = (state_q == WALK_WAIT) && mem_rsp_valid_i;
        payload_take = rsp_take && (idx_q < IDX_W'(WORDS));
        crc_take     = rsp_take && (idx_q == IDX_W'(WORDS));
        crc_ok       = (mem_rsp_data_i[CRC_W-1:0] == crc_val);
        accept       = (state_q == WALK_PRESENT) && dsc_ready_i;
        next_ptr     = ADDR_W'(words[DCW_NEXT_IDX]);
        launch       = ((state_q == WALK_IDLE) && start_i && (first_addr_i != '0) && !err_q)
                     || (accept && (next_ptr != '0));
        hash_word    = (idx_q == IDX_W'(DCW_CTLA_IDX)) ? (mem_rsp_data_i & ~CTLA_MASK)
                                                        : mem_rsp_data_i;
    end

    dcw_crc_acc #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W),
        .POLY   (CRC_POLY),
        .INIT   (CRC_INIT)
    ) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (launch),
        .upd_i  (payload_take),
        .word_i (hash_word),
        .crc_o  (crc_val)
    );

    dcw_word_bank #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (payload_take),
        .wr_idx_i  (idx_q),
        .wr_data_i (mem_rsp_data_i),
        .words_o   (words)
    );

    // Walk sequencer: request, wait, present, follow the next pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
            base_q  <= '0;
            idx_q   <= '0;
            chk_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                WALK_IDLE: begin
                    if (launch) begin
                        base_q  <= first_addr_i;
                        idx_q   <= '0;
                        chk_q   <= check_en_i;
                        state_q <= WALK_REQ;
                    end
                end
                WALK_REQ: state_q <= WALK_WAIT;
                WALK_WAIT: begin
                    if (crc_take) begin
                        state_q <= crc_ok ? WALK_PRESENT : WALK_IDLE;
                    end else if (payload_take) begin
                        if (idx_q == IDX_W'(WORDS - 1) && !chk_q) begin
                            state_q <= WALK_PRESENT;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= WALK_REQ;
                        end
                    end
                end
                WALK_PRESENT: begin
                    if (accept) begin
                        if (next_ptr == '0) begin
                            done_q  <= 1'b1;
                            state_q <= WALK_IDLE;
                        end else begin
                            base_q  <= next_ptr;
                            idx_q   <= '0;
                            state_q <= WALK_REQ;
                        end
                    end
                end
                default: state_q <= WALK_IDLE;
            endcase
        end
    end

    // Sticky integrity error: set on CRC mismatch, cleared by pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                  err_q <= 1'b0;
        else if (crc_take && !crc_ok) err_q <= 1'b1;
        else if (err_clr_i)          err_q <= 1'b0;
    end

    assign mem_req_valid_o = (state_q == WALK_REQ);
    assign mem_req_addr_o  = base_q + (ADDR_W'(idx_q) << BYTE_SHIFT);
    assign dsc_valid_o     = (state_q == WALK_PRESENT);
    assign dsc_src_o       = words[0];
    assign dsc_dst_o       = words[1];
    assign dsc_ctla_o      = words[DCW_CTLA_IDX];
    assign dsc_ctlb_o      = words[3];
    assign dsc_next_o      = words[DCW_NEXT_IDX];
    assign integ_err_o     = err_q;
    assign busy_o          = (state_q != WALK_IDLE);
    assign done_o          = done_q;

    // Requests are single-cycle pulses; a response must intervene.
    assert_single_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |=> !mem_req_valid_o);

    // A presented descriptor holds until accepted.
    assert_hold_until_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_valid_o && !dsc_ready_i) |=> (dsc_valid_o && $stable(dsc_src_o)
            && $stable(dsc_dst_o) && $stable(dsc_ctla_o) && $stable(dsc_ctlb_o)
            && $stable(dsc_next_o)));

    // The error stays set unless cleared.
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_err_o && !err_clr_i) |=> integ_err_o);

    // No fetch while the error is set.
    assert_no_fetch_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        integ_err_o |-> !mem_req_valid_o);

    // A clear pulse removes a set error.
    assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_i && integ_err_o) |=> !integ_err_o);

    // Done follows an accepted descriptor and lasts one cycle.
    assert_done_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(dsc_valid_o && dsc_ready_i) && !dsc_valid_o));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: tb/tb_dscr_chain_walker.sv
`timescale 1ns/1ps
module tb_dscr_chain_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] first_addr_i = '0;
    logic        check_en_i = 1'b0;
    logic        err_clr_i = 1'b0;
    logic        mem_req_valid_o;
    logic [31:0] mem_req_addr_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [31:0] mem_rsp_data_i = '0;
    logic        dsc_valid_o;
    logic        dsc_ready_i = 1'b0;
    logic [31:0] dsc_src_o, dsc_dst_o, dsc_ctla_o, dsc_ctlb_o, dsc_next_o;
    logic        integ_err_o, busy_o, done_o;

    dscr_chain_walker dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .first_addr_i(first_addr_i),
        .check_en_i(check_en_i), .err_clr_i(err_clr_i),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
        .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
        .dsc_valid_o(dsc_valid_o), .dsc_ready_i(dsc_ready_i),
        .dsc_src_o(dsc_src_o), .dsc_dst_o(dsc_dst_o), .dsc_ctla_o(dsc_ctla_o),
        .dsc_ctlb_o(dsc_ctlb_o), .dsc_next_o(dsc_next_o),
        .integ_err_o(integ_err_o), .busy_o(busy_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0]  exp_addr [$];
    logic [159:0] exp_desc [$];
    logic [31:0]  bad_addr = 32'hFFFF_FFFF;

    bit          ref_err = 0, pend_err = 0, pend_clr = 0, pend_done = 0;
    bit          outstanding = 0;
    int          lat_cnt = 0;
    logic [31:0] rsp_addr = '0;
    bit          do_start = 0, do_clr = 0, ready_rand = 1;
    logic [31:0] start_addr = '0;
    bit          start_chk = 0;

    task automatic check(input bit ok, input string req, input logic [159:0] act,
                         input logic [159:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_crc(input logic [31:0] w0, w1, w2, w3, w4);
        logic [31:0] seq [5];
        logic [15:0] r;
        seq[0] = w0; seq[1] = w1; seq[2] = w2 & 32'h7FFF_0000; seq[3] = w3; seq[4] = w4;
        r = 16'hFFFF;
        foreach (seq[k]) begin
            for (int b = 31; b >= 0; b--) begin
                if (r[15] != seq[k][b]) r = (r << 1) ^ 16'h1021;
                else                    r = r << 1;
            end
        end
        return r;
    endfunction

    // Places a descriptor in memory; bad corrupts the stored CRC.
    task automatic put_desc(input logic [31:0] a, src, dst, ctla, ctlb, nxt, input bit bad);
        logic [15:0] c;
        c = model_crc(src, dst, ctla, ctlb, nxt);
        if (bad) c = c ^ 16'h0001;
        mem[a] = src; mem[a+4] = dst; mem[a+8] = ctla; mem[a+12] = ctlb;
        mem[a+16] = nxt; mem[a+20] = {16'hA5C3, c};
    endtask

    task automatic expect_desc(input logic [31:0] a, input bit chk, input bit shown);
        for (int k = 0; k < (chk ? 6 : 5); k++) exp_addr.push_back(a + 32'(4 * k));
        if (shown) exp_desc.push_back({mem[a], mem[a+4], mem[a+8], mem[a+12], mem[a+16]});
    endtask

    // Cycle-by-cycle model: memory responder, ready driver and output comparison.
    always @(negedge clk) begin
        logic [159:0] got;
        logic [159:0] want;
        bit exp_done;
        if (rst_n) begin
            if (pend_err) ref_err = 1;
            if (pend_clr) ref_err = 0;
            exp_done  = pend_done;
            pend_err  = 0; pend_clr = 0; pend_done = 0;
            check(integ_err_o == ref_err, "R7/R8 integrity error", 160'(integ_err_o), 160'(ref_err));
            check(done_o == exp_done, "R10 done pulse", 160'(done_o), 160'(exp_done));

            mem_rsp_valid_i = 0;
            if (outstanding) begin
                lat_cnt--;
                if (lat_cnt == 0) begin
                    mem_rsp_valid_i = 1;
                    mem_rsp_data_i  = mem.exists(rsp_addr) ? mem[rsp_addr] : 32'h0;
                    outstanding     = 0;
                    if (rsp_addr == bad_addr) pend_err = 1;
                end
            end
            if (mem_req_valid_o) begin
                check(!outstanding, "R3 one outstanding read", 160'(outstanding), 160'(0));
                check(!ref_err, "R7 no fetch while error", 160'(ref_err), 160'(0));
                if (exp_addr.size() == 0) begin
                    check(0, "R2/R3 unexpected request", 160'(mem_req_addr_o), 160'(0));
                end else begin
                    want = 160'(exp_addr.pop_front());
                    check(160'(mem_req_addr_o) == want, "R3 request address",
                          160'(mem_req_addr_o), want);
                end
                outstanding = 1;
                rsp_addr    = mem_req_addr_o;
                lat_cnt     = 1 + int'($urandom_range(0, 2));
            end

            dsc_ready_i = ready_rand ? ($urandom_range(0, 2) != 0) : 1'b1;
            if (dsc_valid_o && dsc_ready_i) begin
                got = {dsc_src_o, dsc_dst_o, dsc_ctla_o, dsc_ctlb_o, dsc_next_o};
                if (exp_desc.size() == 0) begin
                    check(0, "R6/R7 unexpected descriptor", got, 160'(0));
                end else begin
                    want = exp_desc.pop_front();
                    check(got == want, "R5/R6 presented fields", got, want);
                end
                if (dsc_next_o == 32'h0) pend_done = 1;
            end

            start_i      = do_start;
            first_addr_i = start_addr;
            check_en_i   = start_chk;
            do_start     = 0;
            err_clr_i    = do_clr;
            if (do_clr) pend_clr = 1;
            do_clr       = 0;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=50000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic go(input logic [31:0] a, input bit chk);
        @(posedge clk);
        start_addr = a; start_chk = chk; do_start = 1;
        repeat (4) @(posedge clk);
    endtask

    task automatic settle();
        int guard = 0;
        while ((busy_o || exp_addr.size() != 0 || exp_desc.size() != 0) && guard < 5000) begin
            @(posedge clk);
            guard++;
        end
        repeat (4) @(posedge clk);
        check(exp_addr.size() == 0, "R3 all expected reads issued", 160'(exp_addr.size()), 160'(0));
        check(exp_desc.size() == 0, "R6 all descriptors presented", 160'(exp_desc.size()), 160'(0));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({mem_req_valid_o, dsc_valid_o, integ_err_o, done_o, busy_o} == 5'b0,
              "R1 reset state", 160'({mem_req_valid_o, dsc_valid_o, integ_err_o, done_o, busy_o}),
              160'(0));
        rst_n = 1;
        repeat (2) @(posedge clk);

        // R4 R5 R10: three-descriptor chain, control A with size and done bits set.
        put_desc(32'h100, 32'h1111_0000, 32'h2222_0000, 32'h8001_00FF, 32'h0000_0042, 32'h200, 0);
        put_desc(32'h200, 32'h1111_1000, 32'h2222_1000, 32'hFFFF_FFFF, 32'h0000_0007, 32'h180, 0);
        put_desc(32'h180, 32'h1111_2000, 32'h2222_2000, 32'h0003_1234, 32'h0000_0001, 32'h0, 0);
        expect_desc(32'h100, 1, 1); expect_desc(32'h200, 1, 1); expect_desc(32'h180, 1, 1);
        go(32'h100, 1);
        settle();
        check(!integ_err_o, "R4 matching CRCs give no error", 160'(integ_err_o), 160'(0));

        // R9: check disabled, corrupted CRC word is neither read nor checked.
        put_desc(32'h300, 32'hAAAA_0001, 32'hBBBB_0001, 32'h0000_0010, 32'h0, 32'h0, 1);
        expect_desc(32'h300, 0, 1);
        go(32'h300, 0);
        settle();
        check(!integ_err_o, "R9 no error with check disabled", 160'(integ_err_o), 160'(0));

        // R2: zero first address does nothing.
        go(32'h0, 1);
        check(!busy_o, "R2 zero address ignored", 160'(busy_o), 160'(0));

        // R7: second descriptor fails its CRC.
        put_desc(32'h400, 32'hC0DE_0000, 32'hD00D_0000, 32'h0000_0004, 32'h5, 32'h500, 0);
        put_desc(32'h500, 32'hC0DE_1000, 32'hD00D_1000, 32'h0000_0008, 32'h6, 32'h0, 1);
        bad_addr = 32'h514;
        expect_desc(32'h400, 1, 1); expect_desc(32'h500, 1, 0);
        go(32'h400, 1);
        settle();
        check(integ_err_o, "R7 mismatch sets error", 160'(integ_err_o), 160'(1));
        check(!busy_o, "R7 walk halted", 160'(busy_o), 160'(0));
        bad_addr = 32'hFFFF_FFFF;

        // R2 R7: start refused while error is set.
        go(32'h400, 1);
        check(!busy_o, "R2 start refused during error", 160'(busy_o), 160'(0));
        check(integ_err_o, "R7 error still set", 160'(integ_err_o), 160'(1));

        // R8: clear the error.
        @(posedge clk);
        do_clr = 1;
        repeat (3) @(posedge clk);
        check(!integ_err_o, "R8 clear removes error", 160'(integ_err_o), 160'(0));

        // R4 R5 R6: single descriptor after recovery, ready held high.
        ready_rand = 0;
        put_desc(32'h600, 32'h0, 32'hFFFF_FFFC, 32'h7FFF_0000, 32'hFFFF_FFFF, 32'h0, 0);
        expect_desc(32'h600, 1, 1);
        go(32'h600, 1);
        settle();
        ready_rand = 1;

        // R5: only masked control A bits may differ from the hashed value.
        put_desc(32'h700, 32'h1, 32'h2, 32'h0000_0000, 32'h3, 32'h0, 0);
        mem[32'h708] = 32'h8000_FFFF;
        expect_desc(32'h700, 1, 1);
        go(32'h700, 1);
        settle();
        check(!integ_err_o, "R5 masked fields ignored", 160'(integ_err_o), 160'(0));

        put_desc(32'h800, 32'h1, 32'h2, 32'h0000_0000, 32'h3, 32'h0, 0);
        mem[32'h808] = 32'h0001_0000;
        bad_addr = 32'h814;
        expect_desc(32'h800, 1, 0);
        go(32'h800, 1);
        settle();
        check(integ_err_o, "R4/R5 unmasked control A bit is hashed", 160'(integ_err_o), 160'(1));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule